// File: doc/BRIEF.md
# CAN Receive Mailbox Matcher

This block decides which message buffer receives a frame that the CAN protocol engine has just accepted, and it tells the surrounding buffer storage what status code to write there. Each buffer has a stored identifier, a receive mask and a two-bit status code. The block reads these as flat vectors and compares them all in parallel against the received identifier. Two cycles after the valid strobe, it issues a single write strobe with the chosen index and the new code, together with a one-hot interrupt-flag pulse.

There are two filtering schemes. In the shared scheme, one global mask covers most buffers, and buffers 14 and 15 each use a dedicated mask. The frame lands in the lowest-numbered matching buffer, and if that buffer still holds an unread frame it is flagged as overrun. In the per-buffer scheme, every buffer uses its own mask, and the search takes the lowest matching buffer that is empty. Buffers that share an identifier therefore fill up in order, like a queue. The block can also drop frames that the node sent itself, and it limits the search to a programmable number of buffers.

Top module: `can_rx_matcher`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wr_en` is 0 and `irq_flags` is all zero.
- R2: A buffer matches when `rx_id` and its stored identifier agree at every bit where the selected mask bit is 1. Mask bits of 0 are ignored.
- R3: When `indiv_mode` is 0, buffer 14 uses `ded_mask_a` and buffer 15 uses `ded_mask_b`. Every other buffer uses `glb_mask`, and the per-buffer masks `mb_mask` are ignored.
- R4: When `indiv_mode` is 0, the lowest-numbered matching buffer is chosen. The new code is FULL (2) if that buffer was EMPTY (1), and OVERRUN (3) if it was FULL (2) or OVERRUN (3).
- R5: When `indiv_mode` is 1, each buffer uses its own mask from `mb_mask`. The lowest-numbered matching buffer whose code is EMPTY (1) is chosen, and the new code is FULL (2).
- R6: When `indiv_mode` is 1 and no matching buffer is EMPTY, the highest-numbered matching buffer is chosen, and the new code is OVERRUN (3).
- R7: A buffer whose code is INACTIVE (0), or whose index is greater than `last_mb`, never matches. The reset value of `last_mb` used by the system is 15, which gives 16 buffers.
- R8: When `self_rx_dis` is 1, a frame with `rx_self` = 1 produces no write and no interrupt. When `self_rx_dis` is 0, self-sent frames are handled like any other frame.
- R9: A frame that matches no buffer produces no write strobe and no interrupt flag.
- R10: The result of a frame strobed at clock edge k appears after edge k+2 and lasts exactly one cycle. `irq_flags` then has exactly the bit at `wr_idx` set, and it is zero whenever `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame identifier is present |
| rx_id | input | ID_W | Received frame identifier |
| rx_self | input | 1 | Frame was transmitted by this node |
| indiv_mode | input | 1 | 0 = shared global masking, 1 = per-buffer masking with queueing |
| self_rx_dis | input | 1 | Drop frames that this node transmitted |
| last_mb | input | LAST_W | Highest buffer index that takes part in the search |
| glb_mask | input | ID_W | Shared mask for buffers other than 14 and 15 |
| ded_mask_a | input | ID_W | Dedicated mask of buffer 14 in shared mode |
| ded_mask_b | input | ID_W | Dedicated mask of buffer 15 in shared mode |
| mb_id | input | NUM_MB*ID_W | Stored identifiers; buffer i at bits [i*ID_W +: ID_W] |
| mb_mask | input | NUM_MB*ID_W | Per-buffer masks, same packing as mb_id |
| mb_code | input | NUM_MB*2 | Status codes, buffer i at bits [2*i +: 2]: 0 inactive, 1 empty, 2 full, 3 overrun |
| wr_en | output | 1 | One-cycle write strobe for the chosen buffer |
| wr_idx | output | $clog2(NUM_MB) | Index of the chosen buffer |
| wr_code | output | 2 | New status code for that buffer |
| irq_flags | output | NUM_MB | One-hot interrupt-flag pulse |

## Verification
A corrupted hit or empty vector makes the block pick a different buffer or write the wrong code. This is visible at `wr_idx` and `wr_code` two cycles after the strobe. A sweep that stores frames twice into the same buffers exposes a wrong FULL/OVERRUN choice on the second pass. A stuck pipeline valid appears as a strobe that is missing, longer than one cycle, or out of step with `irq_flags` on the very next cycle.

// File: rtl/can_mb_pkg.sv
package can_mb_pkg;
  typedef enum logic [1:0] {
    MB_INACTIVE = 2'd0,
    MB_EMPTY    = 2'd1,
    MB_FULL     = 2'd2,
    MB_OVERRUN  = 2'd3
  } mb_code_e;
endpackage

// File: rtl/can_mb_cmp.sv
// Parallel identifier compare: one lane per message buffer.
module can_mb_cmp
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  parameter int LAST_W = 6
) (
  input  logic [ID_W-1:0]        rx_id,
  input  logic                   indiv_mode,
  input  logic [LAST_W-1:0]      last_mb,
  input  logic [ID_W-1:0]        glb_mask,
  input  logic [ID_W-1:0]        ded_mask_a,
  input  logic [ID_W-1:0]        ded_mask_b,
  input  logic [NUM_MB*ID_W-1:0] mb_id,
  input  logic [NUM_MB*ID_W-1:0] mb_mask,
  input  logic [NUM_MB*2-1:0]    mb_code,
  output logic [NUM_MB-1:0]      hit,
  output logic [NUM_MB-1:0]      empty
);
  for (genvar i = 0; i < NUM_MB; i++) begin : g_lane
    logic [ID_W-1:0] shared_m;
    logic [ID_W-1:0] use_m;
    logic [1:0]      code;
    logic            active;

    // buffers 14 and 15 carry dedicated masks in shared mode
    if (i == 14) begin : g_ded_a
      assign shared_m = ded_mask_a;
    end else if (i == 15) begin : g_ded_b
      assign shared_m = ded_mask_b;
    end else begin : g_glb
      assign shared_m = glb_mask;
    end

    assign use_m  = indiv_mode ? mb_mask[i*ID_W +: ID_W] : shared_m;
    assign code   = mb_code[2*i +: 2];
    assign active = (code != MB_INACTIVE) && (32'(i) <= 32'(last_mb));
    assign hit[i] = active && (((rx_id ^ mb_id[i*ID_W +: ID_W]) & use_m) == '0);
    assign empty[i] = (code == MB_EMPTY);
  end
endmodule

// File: rtl/can_mb_pick.sv
// Selects the destination buffer and new status code from the hit vectors.
module can_mb_pick
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_MB-1:0] hit,
  input  logic [NUM_MB-1:0] empty,
  input  logic              indiv_mode,
  output logic              found,
  output logic [IDX_W-1:0]  idx,
  output mb_code_e          code
);
  logic [NUM_MB-1:0] hit_empty;
  logic [IDX_W-1:0]  first_hit;
  logic [IDX_W-1:0]  first_free;
  logic [IDX_W-1:0]  last_hit;

  assign hit_empty = hit & empty;
  assign found     = |hit;

  always_comb begin
    first_hit  = '0;
    first_free = '0;
    last_hit   = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (hit[i])       first_hit  = IDX_W'(i);
      if (hit_empty[i]) first_free = IDX_W'(i);
    end
    for (int i = 0; i < NUM_MB; i++) begin
      if (hit[i]) last_hit = IDX_W'(i);
    end
  end

  always_comb begin
    if (!indiv_mode) begin
      idx  = first_hit;
      code = empty[first_hit] ? MB_FULL : MB_OVERRUN;
    end else if (|hit_empty) begin
      idx  = first_free;
      code = MB_FULL;
    end else begin
      idx  = last_hit;
      code = MB_OVERRUN;
    end
  end
endmodule

// File: rtl/can_rx_matcher.sv
// Receive mailbox matcher: two register stages from strobe to write strobe.
module can_rx_matcher
  import can_mb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 11,
  parameter int LAST_W = 6,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rx_valid,
  input  logic [ID_W-1:0]        rx_id,
  input  logic                   rx_self,
  input  logic                   indiv_mode,
  input  logic                   self_rx_dis,
  input  logic [LAST_W-1:0]      last_mb,
  input  logic [ID_W-1:0]        glb_mask,
  input  logic [ID_W-1:0]        ded_mask_a,
  input  logic [ID_W-1:0]        ded_mask_b,
  input  logic [NUM_MB*ID_W-1:0] mb_id,
  input  logic [NUM_MB*ID_W-1:0] mb_mask,
  input  logic [NUM_MB*2-1:0]    mb_code,
  output logic                   wr_en,
  output logic [IDX_W-1:0]       wr_idx,
  output logic [1:0]             wr_code,
  output logic [NUM_MB-1:0]      irq_flags
);
  logic [NUM_MB-1:0] hit_c, empty_c;
  logic [NUM_MB-1:0] s1_hit, s1_empty;
  logic              s1_valid, s1_indiv;
  logic              found_c;
  logic [IDX_W-1:0]  idx_c;
  mb_code_e          code_c;

  can_mb_cmp #(.NUM_MB(NUM_MB), .ID_W(ID_W), .LAST_W(LAST_W)) u_cmp (
    .rx_id(rx_id), .indiv_mode(indiv_mode), .last_mb(last_mb),
    .glb_mask(glb_mask), .ded_mask_a(ded_mask_a), .ded_mask_b(ded_mask_b),
    .mb_id(mb_id), .mb_mask(mb_mask), .mb_code(mb_code),
    .hit(hit_c), .empty(empty_c)
  );

  // stage 1: capture compare results, drop self-sent frames if asked
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= '0;
      s1_empty <= '0;
      s1_indiv <= 1'b0;
    end else begin
      s1_valid <= rx_valid && !(rx_self && self_rx_dis);
      s1_hit   <= hit_c;
      s1_empty <= empty_c;
      s1_indiv <= indiv_mode;
    end
  end

  can_mb_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
    .hit(s1_hit), .empty(s1_empty), .indiv_mode(s1_indiv),
    .found(found_c), .idx(idx_c), .code(code_c)
  );

  // stage 2: registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_code   <= 2'd0;
      irq_flags <= '0;
    end else begin
      wr_en     <= s1_valid && found_c;
      wr_idx    <= idx_c;
      wr_code   <= code_c;
      irq_flags <= (s1_valid && found_c) ? (NUM_MB'(1) << idx_c) : '0;
    end
  end
endmodule

// File: rtl/can_rx_matcher_chk.sv
module can_rx_matcher_chk #(
  parameter int NUM_MB = 16,
  parameter int LAST_W = 6,
  localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_self,
  input logic              self_rx_dis,
  input logic [LAST_W-1:0] last_mb,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_code,
  input logic [NUM_MB-1:0] irq_flags
);
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_flags));

  a_r10_irq_with_wr: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (irq_flags == (NUM_MB'(1) << wr_idx)));

  a_r10_no_irq_idle: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> (irq_flags == '0));

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid, 2));

  a_r8_self_drop: assert property (@(posedge clk) disable iff (rst)
    $past(rx_valid && rx_self && self_rx_dis, 2) |-> !wr_en);

  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_idx) <= 32'($past(last_mb, 2))));

  a_r4_code_kind: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_code[1]);
endmodule

bind can_rx_matcher can_rx_matcher_chk #(.NUM_MB(NUM_MB), .LAST_W(LAST_W)) u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_self(rx_self),
  .self_rx_dis(self_rx_dis), .last_mb(last_mb), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_code(wr_code), .irq_flags(irq_flags)
);

// File: tb/can_rx_matcher_test.sv
module can_rx_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 16;
  localparam int IDW = 11;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rst, rx_valid, rx_self, indiv_mode, self_rx_dis;
  logic [IDW-1:0]   rx_id, glb_mask, ded_mask_a, ded_mask_b;
  logic [5:0]       last_mb;
  logic [IDW-1:0]   m_id   [NMB];
  logic [IDW-1:0]   m_mask [NMB];
  logic [1:0]       m_code [NMB];
  logic [NMB*IDW-1:0] mb_id_f, mb_mask_f;
  logic [NMB*2-1:0]   mb_code_f;
  logic             wr_en;
  logic [3:0]       wr_idx;
  logic [1:0]       wr_code;
  logic [NMB-1:0]   irq_flags;

  always_comb begin
    for (int i = 0; i < NMB; i++) begin
      mb_id_f[i*IDW +: IDW]   = m_id[i];
      mb_mask_f[i*IDW +: IDW] = m_mask[i];
      mb_code_f[2*i +: 2]     = m_code[i];
    end
  end

  can_rx_matcher #(.NUM_MB(NMB), .ID_W(IDW), .LAST_W(6)) uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_self(rx_self),
    .indiv_mode(indiv_mode), .self_rx_dis(self_rx_dis), .last_mb(last_mb),
    .glb_mask(glb_mask), .ded_mask_a(ded_mask_a), .ded_mask_b(ded_mask_b),
    .mb_id(mb_id_f), .mb_mask(mb_mask_f), .mb_code(mb_code_f),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_code(wr_code), .irq_flags(irq_flags)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic expect_pick(input logic [IDW-1:0] id, input bit slf,
                             output bit en, output int idx, output int code);
    int fh, fe, lh;
    logic [IDW-1:0] m;
    en = 1'b0; idx = 0; code = 0;
    fh = -1; fe = -1; lh = -1;
    if (slf && self_rx_dis) return;
    for (int i = 0; i < NMB; i++) begin
      if (indiv_mode)   m = m_mask[i];
      else if (i == 14) m = ded_mask_a;
      else if (i == 15) m = ded_mask_b;
      else              m = glb_mask;
      if (m_code[i] != 2'd0 && i <= int'(last_mb) && ((id ^ m_id[i]) & m) == '0) begin
        if (fh < 0) fh = i;
        if (fe < 0 && m_code[i] == 2'd1) fe = i;
        lh = i;
      end
    end
    if (fh < 0) return;
    en = 1'b1;
    if (!indiv_mode) begin
      idx = fh; code = (m_code[fh] == 2'd1) ? 2 : 3;
    end else if (fe >= 0) begin
      idx = fe; code = 2;
    end else begin
      idx = lh; code = 3;
    end
  endtask

  task automatic frame(input logic [IDW-1:0] id, input bit slf, input string tag);
    bit e_en; int e_idx, e_code;
    expect_pick(id, slf, e_en, e_idx, e_code);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_self = slf;
    @(negedge clk);
    rx_valid = 1'b0; rx_self = 1'b0;
    chk(!wr_en, "R10", "early strobe", int'(wr_en), 0);
    @(negedge clk);
    chk(wr_en == e_en, tag, "wr_en", int'(wr_en), int'(e_en));
    if (e_en) begin
      chk(int'(wr_idx) == e_idx, tag, "wr_idx", int'(wr_idx), e_idx);
      chk(int'(wr_code) == e_code, tag, "wr_code", int'(wr_code), e_code);
      chk(irq_flags == (NMB'(1) << e_idx), "R10", "irq_flags",
          int'(irq_flags), 1 << e_idx);
      m_code[e_idx] = 2'(e_code);
    end else begin
      chk(irq_flags == '0, tag, "irq_flags idle", int'(irq_flags), 0);
    end
    @(negedge clk);
    chk(!wr_en && irq_flags == '0, "R10", "pulse width", int'(wr_en), 0);
  endtask

  task automatic clear_codes();
    for (int i = 0; i < NMB; i++) m_code[i] = 2'd1;
  endtask

  initial begin
    rst = 1'b1; rx_valid = 1'b0; rx_self = 1'b0; rx_id = '0;
    indiv_mode = 1'b0; self_rx_dis = 1'b0; last_mb = 6'h0F;
    glb_mask = 11'h7FF; ded_mask_a = 11'h7FF; ded_mask_b = 11'h7FF;
    for (int i = 0; i < NMB; i++) begin
      m_id[i] = 11'(i * 3); m_mask[i] = 11'h7FF; m_code[i] = 2'd1;
    end
    repeat (3) @(negedge clk);
    chk(!wr_en && irq_flags == '0, "R1", "outputs in reset", int'(wr_en), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && irq_flags == '0, "R1", "outputs after reset", int'(wr_en), 0);

    // shared mode: exact sweep, twice so the second pass overruns
    for (int k = 0; k < 48; k++) frame(11'(k), 1'b0, "R4");
    for (int k = 0; k < 48; k++) frame(11'(k), 1'b0, "R4");

    // partial global mask: low nibble ignored
    clear_codes();
    glb_mask = 11'h7F0;
    for (int k = 0; k < 64; k++) frame(11'(k), 1'b0, "R2");
    glb_mask = 11'h7FF;

    // dedicated masks of buffers 14 and 15
    clear_codes();
    m_id[14] = 11'h3C3; m_id[15] = 11'h5A5; m_mask[15] = 11'h000;
    ded_mask_a = 11'h000;
    frame(11'h5A5, 1'b0, "R3");
    ded_mask_a = 11'h7FF;
    frame(11'h5A5, 1'b0, "R3");
    frame(11'h3C3, 1'b0, "R3");
    frame(11'h700, 1'b0, "R9");
    m_mask[15] = 11'h7FF;

    // per-buffer mode: queue over buffers 2..5
    indiv_mode = 1'b1; ded_mask_a = 11'h000;
    clear_codes();
    for (int i = 2; i <= 5; i++) m_id[i] = 11'h155;
    for (int n = 0; n < 4; n++) frame(11'h155, 1'b0, "R5");
    frame(11'h155, 1'b0, "R6");
    frame(11'h155, 1'b0, "R6");
    m_id[9] = 11'h009; m_mask[9] = 11'h00F;
    frame(11'h7F9, 1'b0, "R5");
    frame(11'h7F9, 1'b0, "R6");

    // inactive buffers and search limit
    clear_codes();
    m_code[2] = 2'd0; last_mb = 6'd3;
    frame(11'h155, 1'b0, "R7");
    frame(11'h155, 1'b0, "R7");
    last_mb = 6'd1;
    frame(11'h155, 1'b0, "R7");
    frame(11'h003, 1'b0, "R7");
    last_mb = 6'h0F;

    // self-reception handling
    clear_codes();
    self_rx_dis = 1'b1;
    frame(11'h155, 1'b1, "R8");
    frame(11'h155, 1'b0, "R8");
    self_rx_dis = 1'b0;
    frame(11'h155, 1'b1, "R8");

    // no match at all
    frame(11'h7FF, 1'b0, "R9");
    frame(11'h600, 1'b0, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule